// File: doc/BRIEF.md
# Sample-Rate Speed Mode Detector

This block chooses which oversampling speed class the downstream interpolation filters run in: half, normal or double. A two-bit selector either forces one class directly or hands the choice to an automatic path. The automatic path counts master clock cycles between rising edges of the channel (frame) clock and sorts that ratio into a speed class.

The channel clock arrives asynchronously and is brought into the master clock domain through a synchronizer before its rising edges are detected. A measured ratio is only trusted when two back-to-back measurements agree within a small tolerance. A ratio that fits no known multiple leaves the previous class in place and raises an unlock flag. Every change of the resolved class produces a single-cycle reinitialization pulse, which the datapath uses to restart its filters cleanly.

Top module: `speed_mode_detect`

## Requirements
- R1: With `mode_sel` 00, 01 or 10 the `speed` output becomes 00 (normal), 01 (double) or 10 (half), one clock after the selector is sampled.
- R2: `mode_sel` 11 selects automatic detection; after reset `speed` is 00 (normal) and `unlock` and `reinit_pulse` are 0.
- R3: In automatic mode, a channel clock period of 1024 or 1536 master clocks, measured between synchronized rising edges, resolves to half speed (10).
- R4: In automatic mode, a period of 512 or 768 master clocks resolves to normal speed (00).
- R5: In automatic mode, a period of 128, 192, 256 or 384 master clocks resolves to double speed (01).
- R6: A measured period within ±2 clocks of a table ratio counts as that ratio; a period 3 or more away from every entry matches none.
- R7: A measurement is acted on only when it lies within ±2 clocks of the measurement just before it; periods that alternate between unlike values leave `speed` and `unlock` unchanged.
- R8: When two agreeing measurements match no table entry, `speed` keeps its value and `unlock` goes to 1; the next accepted match clears it. `unlock` is 0 while a forced mode is selected.
- R9: `reinit_pulse` is high for exactly the cycles in which `speed` differs from its value in the preceding cycle, and low otherwise.
- R10: While a forced mode is selected, the channel clock has no effect on `speed`; the automatic result keeps tracking in the background and appears once `mode_sel` returns to 11.
- R11: `speed` never shows the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk_async | input | 1 | Channel clock, asynchronous to `clk` |
| mode_sel | input | 2 | Speed selector: 00 normal, 01 double, 10 half, 11 automatic |
| speed | output | 2 | Resolved speed class: 00 normal, 01 double, 10 half |
| unlock | output | 1 | Automatic path saw a stable ratio outside the table |
| reinit_pulse | output | 1 | One-cycle pulse on every change of `speed` |

## Verification
On every cycle the checks cover the forced-mode path (speed following the selector one clock later, unlock held low), the legality of the speed code, and the exact correspondence between reinitialization pulses and changes of the speed output. The classification of ratios, the ±2 tolerance edges, the need for two agreeing measurements, the unlock behaviour and background tracking during forced modes depend on whole channel clock periods, so only the bench's directed scenarios can show them.

// File: rtl/smd_pkg.sv
package smd_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_HALF   = 2'b10
  } speed_e;

  localparam int N_RATIO = 8;

  // Ratios in ascending order: 128,192,256,384,512,768,1024,1536
  function automatic int unsigned ratio_at(input int idx);
    int unsigned base;
    base = (idx % 2 == 0) ? 128 : 192;
    return base << (idx / 2);
  endfunction

  function automatic speed_e class_at(input int idx);
    if (idx >= 6)      return SPD_HALF;
    else if (idx >= 4) return SPD_NORMAL;
    else               return SPD_DOUBLE;
  endfunction

endpackage

// File: rtl/smd_sync_edge.sv
module smd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/smd_period_meter.sv
module smd_period_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      armed      <= 1'b0;
      meas       <= '0;
      meas_valid <= 1'b0;
    end else if (edge_i) begin
      cnt        <= CNT_W'(1);
      armed      <= 1'b1;
      meas       <= cnt;
      meas_valid <= armed;
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      meas_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/smd_ratio_classify.sv
module smd_ratio_classify
  import smd_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] meas,
  output logic             hit,
  output speed_e           cls
);
  logic [N_RATIO-1:0] hit_v;
  logic [31:0]        m32;

  assign m32 = 32'(meas);

  for (genvar i = 0; i < N_RATIO; i++) begin : g_entry
    localparam int unsigned R = ratio_at(i);
    assign hit_v[i] = (m32 + TOL >= R) && (m32 <= R + TOL);
  end

  always_comb begin
    cls = SPD_NORMAL;
    for (int i = N_RATIO - 1; i >= 0; i--) begin
      if (hit_v[i]) cls = class_at(i);
    end
  end

  assign hit = |hit_v;
endmodule

// File: rtl/speed_mode_detect.sv
module speed_mode_detect
  import smd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12,
  parameter int TOL         = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrclk_async,
  input  logic [1:0] mode_sel,
  output logic [1:0] speed,
  output logic       unlock,
  output logic       reinit_pulse
);
  localparam logic [1:0] SEL_AUTO = 2'b11;

  logic             lr_rise;
  logic             meas_valid;
  logic [CNT_W-1:0] meas;
  logic             hit;
  speed_e           cls;

  smd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(lrclk_async), .rise(lr_rise)
  );

  smd_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .edge_i(lr_rise),
    .meas_valid(meas_valid), .meas(meas)
  );

  smd_ratio_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
    .meas(meas), .hit(hit), .cls(cls)
  );

  // Qualification: two agreeing measurements in a row
  logic [CNT_W-1:0] prev_meas;
  logic             prev_ok;
  logic [CNT_W-1:0] diff;
  logic             agree;
  speed_e           auto_spd;
  logic             auto_unlock;

  assign diff  = (meas > prev_meas) ? (meas - prev_meas) : (prev_meas - meas);
  assign agree = prev_ok && (32'(diff) <= TOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_meas   <= '0;
      prev_ok     <= 1'b0;
      auto_spd    <= SPD_NORMAL;
      auto_unlock <= 1'b0;
    end else if (meas_valid) begin
      prev_meas <= meas;
      prev_ok   <= 1'b1;
      if (agree) begin
        if (hit) begin
          auto_spd    <= cls;
          auto_unlock <= 1'b0;
        end else begin
          auto_unlock <= 1'b1;
        end
      end
    end
  end

  // Resolution and change pulse
  speed_e spd_next, spd_q;
  logic   unlock_q, pulse_q;

  always_comb begin
    if (mode_sel == SEL_AUTO) spd_next = auto_spd;
    else                      spd_next = speed_e'(mode_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q    <= SPD_NORMAL;
      pulse_q  <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      spd_q    <= spd_next;
      pulse_q  <= (spd_next != spd_q);
      unlock_q <= (mode_sel == SEL_AUTO) && auto_unlock;
    end
  end

  assign speed        = spd_q;
  assign unlock       = unlock_q;
  assign reinit_pulse = pulse_q;
endmodule

// File: rtl/smd_checker.sv
module smd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic [1:0] speed,
  input logic       unlock,
  input logic       reinit_pulse
);
  AST_FORCED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b11) |=> (speed == $past(mode_sel))); // R1

  AST_NO_UNLOCK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b11) |=> !unlock); // R8

  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (speed != $past(speed)) |-> reinit_pulse); // R9

  AST_PULSE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse |-> (speed != $past(speed))); // R9

  AST_SPEED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    speed != 2'b11); // R11
endmodule

bind speed_mode_detect smd_checker u_smd_checker (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
  .speed(speed), .unlock(unlock), .reinit_pulse(reinit_pulse)
);

// File: tb/speed_mode_detect_bench.sv
module speed_mode_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrclk = 1'b0;
  logic [1:0] mode_sel = 2'b11;
  logic [1:0] speed;
  logic       unlock;
  logic       reinit_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int pulse_cnt = 0;
  int per_a = 0;
  int per_b = 0;
  int cur_per = 0;
  bit done = 0;

  localparam logic [1:0] NRM = 2'b00, DBL = 2'b01, HLF = 2'b10;

  always #10 clk = ~clk;

  speed_mode_detect u_speed_mode_detect (
    .clk(clk), .rst_n(rst_n), .lrclk_async(lrclk), .mode_sel(mode_sel),
    .speed(speed), .unlock(unlock), .reinit_pulse(reinit_pulse)
  );

  always @(negedge clk) if (rst_n && reinit_pulse) pulse_cnt++;

  // Channel clock generator, optionally alternating between two periods
  initial begin
    bit use_b;
    use_b = 0;
    forever begin
      if (per_a == 0) @(negedge clk);
      else begin
        int p;
        p = (use_b && per_b != 0) ? per_b : per_a;
        lrclk <= 1'b1;
        repeat (p / 2) @(negedge clk);
        lrclk <= 1'b0;
        repeat (p - p / 2) @(negedge clk);
        use_b = (per_b != 0) ? !use_b : 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_period(input int p);
    int old;
    old = cur_per;
    per_a = p; per_b = 0; cur_per = p;
    repeat (old + 4 * p + 40) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(speed == NRM, "R2 reset speed", speed, NRM);
    check(unlock == 1'b0, "R2 reset unlock", unlock, 0);
    check(reinit_pulse == 1'b0, "R2 reset pulse", reinit_pulse, 0);
  endtask

  task automatic t_forced();
    logic [1:0] codes [3] = '{DBL, HLF, NRM};
    for (int i = 0; i < 3; i++) begin
      pulse_cnt = 0;
      mode_sel = codes[i];
      repeat (3) @(negedge clk);
      check(speed == codes[i], "R1 forced speed", speed, codes[i]);
      check(pulse_cnt == 1, "R9 one pulse per forced change", pulse_cnt, 1);
    end
    pulse_cnt = 0;
    mode_sel = 2'b11;
    repeat (3) @(negedge clk);
    check(speed == NRM, "R2 auto with no channel clock", speed, NRM);
    check(pulse_cnt == 0, "R9 no pulse without change", pulse_cnt, 0);
  endtask

  task automatic t_auto(input int p, input logic [1:0] exp, input int exp_pulses, input string tag);
    pulse_cnt = 0;
    run_period(p);
    check(speed == exp, tag, speed, exp);
    check(unlock == 1'b0, {tag, " unlock"}, unlock, 0);
    check(pulse_cnt == exp_pulses, "R9 pulse count", pulse_cnt, exp_pulses);
  endtask

  task automatic t_unlock(input int p, input logic [1:0] held, input string tag);
    pulse_cnt = 0;
    run_period(p);
    check(speed == held, {tag, " speed held"}, speed, held);
    check(unlock == 1'b1, {tag, " unlock raised"}, unlock, 1);
    check(pulse_cnt == 0, "R9 no pulse on unlock", pulse_cnt, 0);
  endtask

  task automatic t_forced_ignores();
    pulse_cnt = 0;
    mode_sel = 2'b00;
    repeat (3) @(negedge clk);
    check(speed == NRM, "R10 forced normal", speed, NRM);
    check(unlock == 1'b0, "R8 no unlock when forced", unlock, 0);
    run_period(1024);
    check(speed == NRM, "R10 channel clock ignored", speed, NRM);
    check(pulse_cnt == 1, "R10 only the forced change pulsed", pulse_cnt, 1);
    pulse_cnt = 0;
    mode_sel = 2'b11;
    repeat (3) @(negedge clk);
    check(speed == HLF, "R10 background result applied", speed, HLF);
    check(pulse_cnt == 1, "R9 pulse on return to auto", pulse_cnt, 1);
  endtask

  task automatic t_alternating();
    pulse_cnt = 0;
    per_a = 256; per_b = 640; cur_per = 640;
    repeat (12 * 640) @(negedge clk);
    check(speed == HLF, "R7 alternating periods hold speed", speed, HLF);
    check(unlock == 1'b0, "R7 alternating periods hold unlock", unlock, 0);
    check(pulse_cnt == 0, "R7 no pulse while alternating", pulse_cnt, 0);
    per_b = 0;
  endtask

  initial begin
    repeat (200000 - 100) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_forced();
    t_auto(256,  DBL, 1, "R5 ratio 256");
    t_auto(1024, HLF, 1, "R3 ratio 1024");
    t_auto(768,  NRM, 1, "R4 ratio 768");
    t_auto(1536, HLF, 1, "R3 ratio 1536");
    t_auto(128,  DBL, 1, "R5 ratio 128");
    t_auto(192,  DBL, 0, "R5 ratio 192");
    t_auto(384,  DBL, 0, "R5 ratio 384");
    t_auto(512,  NRM, 1, "R4 ratio 512");
    t_unlock(600, NRM, "R8 ratio 600");
    t_auto(1026, HLF, 1, "R6 ratio 1026 within tolerance");
    t_unlock(1027, HLF, "R6 ratio 1027 outside tolerance");
    t_auto(254,  DBL, 1, "R6 ratio 254 within tolerance");
    t_forced_ignores();
    t_alternating();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule